// File: doc/BRIEF.md
# Protected Translation Buffer

This block is a small, fully associative cache of page translations. It turns a 32-bit virtual address into a physical address. The upper 20 bits are the virtual page number and the lower 12 bits are the offset within the page. Each request also names an access kind: load, store or instruction fetch. The block checks that kind against the rights stored with the matching entry. A permitted access returns the translated address. A forbidden access gets a protection fault in place of a translation, plus a separate flag when the forbidden access was a store. When no valid entry holds the page, the block reports a miss. Whatever sits above the block handles misses and faults.

Entries are loaded through a fill port. A fill carrying a page number that is already cached rewrites that entry in place. A fill carrying a new page number goes to the slot chosen by a rotating pointer. Each entry keeps a reference flag and a dirty flag, and successful accesses set them. A response reports both flags as they stood before that access. A flush input invalidates the whole buffer in a single cycle.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses. `rsp_valid` stays low until a lookup has been registered.
- R2: A lookup presented with `lk_valid` high at a clock edge is answered in the cycle after that edge, with `rsp_valid` high. A cycle without a lookup gives `rsp_valid` low one cycle later.
- R3: On a permitted hit, `rsp_paddr` is the entry's physical page number in bits 31..12, joined to the unchanged bits 11..0 of the virtual address. In every other case `rsp_paddr` is zero.
- R4: When no valid entry holds the virtual page number (bits 31..12), the response has `rsp_miss` high and `rsp_hit` and both fault flags low.
- R5: Access kind codes are 0 = load, 1 = store, 2 = fetch, and 3 = reserved. Rights codes are 0 = read-only, 1 = read/write, 2 = execute-only, and 3 = no access. Permitted combinations:
  - a load needs rights 0 or 1;
  - a store needs rights 1;
  - a fetch needs rights 2.
  Kind 3 and rights 3 are never permitted.
- R6: A matching entry whose rights forbid the access gives `rsp_prot_fault` high, with `rsp_hit` low, `rsp_miss` low and no translated address.
- R7: `rsp_wr_fault` is high exactly when a protection fault is raised for a store.
- R8: A permitted hit sets the entry's reference flag. A faulting access does not set it. `rsp_ref` reports the flag as stored before the current access, and is zero on a miss.
- R9: A permitted store hit sets the entry's dirty flag. Loads, fetches and faults do not set it. `rsp_dirty` reports the flag as stored before the current access. A fill clears both flags of the entry it writes.
- R10: A fill of a page number not present in any valid entry writes the slot under a rotating pointer. The pointer starts at slot 0 after reset and advances by one, modulo 16, after each such fill.
- R11: A fill of a page number already held in a valid entry rewrites that entry's physical page and rights. It does not move the pointer, and it never leaves two valid entries with the same page number.
- R12: `flush` invalidates all entries at the next edge and overrides a fill in the same cycle. A lookup registered at that edge already misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind (0 load, 1 store, 2 fetch, 3 reserved) |
| fill_valid | input | 1 | Write one translation entry |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_ppn | input | 20 | Physical page number of the fill |
| fill_rights | input | 2 | Rights code of the fill |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Permitted translation found |
| rsp_miss | output | 1 | No valid entry for the page |
| rsp_prot_fault | output | 1 | Entry found but access forbidden |
| rsp_wr_fault | output | 1 | Forbidden access was a store |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_ref | output | 1 | Reference flag before this access |
| rsp_dirty | output | 1 | Dirty flag before this access |

## Verification
A corrupted tag or valid bit shows up on the very next lookup to that page, either as a wrong miss or as a hit with the wrong address. A bad rights field turns a hit into a fault, or a fault into a hit, in the cycle after the request. A wrong update of the reference or dirty flag is invisible until the same page is looked up again, and then it appears in `rsp_ref` or `rsp_dirty`. A misplaced rotating pointer stays hidden until a later fill evicts the wrong entry, so the bench fills past a full wrap and then probes both the evicted page and a page that must survive. A behavioural model in the bench is compared with every response field on every cycle, alongside directed checks.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
    typedef enum logic [1:0] {
        KIND_LOAD  = 2'b00,
        KIND_STORE = 2'b01,
        KIND_FETCH = 2'b10,
        KIND_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        RIGHTS_RO   = 2'b00,
        RIGHTS_RW   = 2'b01,
        RIGHTS_XO   = 2'b10,
        RIGHTS_NONE = 2'b11
    } rights_e;
endpackage

// File: rtl/xlat_cam_match.sv
`timescale 1ns/1ps
module xlat_cam_match #(
    parameter int N_ENTRIES = 16,
    parameter int VPN_W     = 20,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic [N_ENTRIES-1:0]            entry_valid,
    input  logic [N_ENTRIES-1:0][VPN_W-1:0] entry_vpn,
    input  logic [VPN_W-1:0]                key,
    output logic [N_ENTRIES-1:0]            match,
    output logic                            any,
    output logic [IDX_W-1:0]                idx
);
    // One comparator per entry.
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign match[g] = entry_valid[g] && (entry_vpn[g] == key);
    end

    // Entries are unique, so an OR of the matching indices is the encoded index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end

    assign any = |match;
endmodule

// File: rtl/xlat_rights_check.sv
`timescale 1ns/1ps
module xlat_rights_check
    import xlat_pkg::*;
(
    input  logic [1:0] kind,
    input  logic [1:0] rights,
    output logic       allow,
    output logic       store_deny
);
    always_comb begin
        unique case (acc_kind_e'(kind))
            KIND_LOAD:  allow = (rights == RIGHTS_RO) || (rights == RIGHTS_RW);
            KIND_STORE: allow = (rights == RIGHTS_RW);
            KIND_FETCH: allow = (rights == RIGHTS_XO);
            default:    allow = 1'b0;
        endcase
        store_deny = (kind == KIND_STORE) && !allow;
    end
endmodule

// File: rtl/xlat_rr_victim.sv
`timescale 1ns/1ps
module xlat_rr_victim #(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (advance) begin
            ptr_d = (ptr_q == IDX_W'(N_ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R10
    rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> ptr_q == (($past(ptr_q) == IDX_W'(N_ENTRIES - 1)) ? '0 : $past(ptr_q) + 1'b1));

    // R11
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr_q));
endmodule

// File: rtl/xlat_buffer.sv
`timescale 1ns/1ps
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int OFF_W     = 12,
    localparam int VPN_W    = VA_W - OFF_W,
    localparam int PPN_W    = PA_W - OFF_W,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_kind,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [1:0]       fill_rights,
    input  logic             flush,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_prot_fault,
    output logic             rsp_wr_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_ref,
    output logic             rsp_dirty
);
    typedef struct packed {
        logic [N_ENTRIES-1:0]            valid;
        logic [N_ENTRIES-1:0]            refd;
        logic [N_ENTRIES-1:0]            dirty;
        logic [N_ENTRIES-1:0][1:0]       rights;
        logic [N_ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [N_ENTRIES-1:0][VPN_W-1:0] vpn;
    } tbl_t;

    typedef struct packed {
        logic            valid;
        logic [VA_W-1:0] vaddr;
        logic [1:0]      kind;
    } req_t;

    tbl_t tbl_d, tbl_q;
    req_t req_d, req_q;

    logic [N_ENTRIES-1:0] lk_match, fl_match;
    logic                 lk_any, fl_any;
    logic [IDX_W-1:0]     lk_idx, fl_idx, rr_ptr, fill_slot;
    logic                 rr_adv, acc_ok, store_deny;
    logic [1:0]           sel_rights;
    logic [VPN_W-1:0]     req_vpn;

    assign req_vpn    = req_q.vaddr[VA_W-1:OFF_W];
    assign sel_rights = tbl_q.rights[lk_idx];

    xlat_cam_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W)) u_lk_cam (
        .entry_valid (tbl_q.valid),
        .entry_vpn   (tbl_q.vpn),
        .key         (req_vpn),
        .match       (lk_match),
        .any         (lk_any),
        .idx         (lk_idx)
    );

    xlat_cam_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W)) u_fill_cam (
        .entry_valid (tbl_q.valid),
        .entry_vpn   (tbl_q.vpn),
        .key         (fill_vpn),
        .match       (fl_match),
        .any         (fl_any),
        .idx         (fl_idx)
    );

    xlat_rights_check u_rights (
        .kind       (req_q.kind),
        .rights     (sel_rights),
        .allow      (acc_ok),
        .store_deny (store_deny)
    );

    xlat_rr_victim #(.N_ENTRIES(N_ENTRIES)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (rr_adv),
        .ptr     (rr_ptr)
    );

    // Next-state: flag update from the answered lookup, then fill, then flush.
    always_comb begin
        req_d.valid = lk_valid;
        req_d.vaddr = lk_vaddr;
        req_d.kind  = lk_kind;

        tbl_d     = tbl_q;
        rr_adv    = 1'b0;
        fill_slot = fl_any ? fl_idx : rr_ptr;

        if (req_q.valid && lk_any && acc_ok) begin
            tbl_d.refd[lk_idx] = 1'b1;
            if (req_q.kind == KIND_STORE) tbl_d.dirty[lk_idx] = 1'b1;
        end

        if (flush) begin
            tbl_d.valid = '0;
        end else if (fill_valid) begin
            rr_adv                  = !fl_any;
            tbl_d.valid[fill_slot]  = 1'b1;
            tbl_d.refd[fill_slot]   = 1'b0;
            tbl_d.dirty[fill_slot]  = 1'b0;
            tbl_d.rights[fill_slot] = fill_rights;
            tbl_d.ppn[fill_slot]    = fill_ppn;
            tbl_d.vpn[fill_slot]    = fill_vpn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
            req_q <= '0;
        end else begin
            tbl_q <= tbl_d;
            req_q <= req_d;
        end
    end

    assign rsp_valid      = req_q.valid;
    assign rsp_hit        = req_q.valid && lk_any && acc_ok;
    assign rsp_miss       = req_q.valid && !lk_any;
    assign rsp_prot_fault = req_q.valid && lk_any && !acc_ok;
    assign rsp_wr_fault   = req_q.valid && lk_any && store_deny;
    assign rsp_paddr      = rsp_hit ? {tbl_q.ppn[lk_idx], req_q.vaddr[OFF_W-1:0]} : '0;
    assign rsp_ref        = req_q.valid && lk_any && tbl_q.refd[lk_idx];
    assign rsp_dirty      = req_q.valid && lk_any && tbl_q.dirty[lk_idx];

    // R2
    lookup_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R2
    idle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R7
    wr_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_fault |-> rsp_prot_fault);

    // R3
    paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> rsp_paddr == '0);

    // R11
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R12
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> tbl_q.valid == '0);

    // R9
    dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && req_q.kind == KIND_STORE && !flush && !(fill_valid && fill_slot == lk_idx))
        |=> tbl_q.dirty[$past(lk_idx)]);
endmodule

// File: tb/xlat_buffer_bench.sv
`timescale 1ns/1ps
module xlat_buffer_bench;
    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic [1:0]  lk_kind;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [19:0] fill_ppn;
    logic [1:0]  fill_rights;
    logic        flush;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_prot_fault, rsp_wr_fault;
    logic [31:0] rsp_paddr;
    logic        rsp_ref, rsp_dirty;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Behavioural model state
    int          m_vpn [NE];
    int          m_ppn [NE];
    int          m_rt  [NE];
    bit          m_v   [NE];
    bit          m_r   [NE];
    bit          m_d   [NE];
    int          m_ptr;
    bit          q_v;
    logic [31:0] q_va;
    int          q_k;

    always #5 clk = ~clk;

    xlat_buffer u_xlat_buffer (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_kind(lk_kind), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_rights(fill_rights), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_prot_fault(rsp_prot_fault), .rsp_wr_fault(rsp_wr_fault),
        .rsp_paddr(rsp_paddr), .rsp_ref(rsp_ref), .rsp_dirty(rsp_dirty)
    );

    task automatic cmp(input logic [31:0] got, input logic [31:0] exp, input string tag);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int find(input int vpn);
        for (int i = 0; i < NE; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    // Rights rules, R5
    function automatic bit permitted(input int k, input int r);
        if (k == 0) return (r == 0) || (r == 1);
        if (k == 1) return r == 1;
        if (k == 2) return r == 2;
        return 1'b0;
    endfunction

    task automatic tick(input bit lv, input logic [31:0] va, input int k,
                        input bit fv, input int fvpn, input int fppn, input int fr,
                        input bit fl);
        int m, f, t;
        bit e_hit, e_miss, e_pf, e_wf, e_ref, e_dirty;
        logic [31:0] e_pa;
        lk_valid = lv; lk_vaddr = va; lk_kind = 2'(k);
        fill_valid = fv; fill_vpn = 20'(fvpn); fill_ppn = 20'(fppn);
        fill_rights = 2'(fr); flush = fl;
        // model edge
        if (q_v) begin
            m = find(int'(q_va >> 12));
            if (m >= 0 && permitted(q_k, m_rt[m])) begin
                m_r[m] = 1'b1;
                if (q_k == 1) m_d[m] = 1'b1;
            end
        end
        if (fl) begin
            for (int i = 0; i < NE; i++) m_v[i] = 1'b0;
        end else if (fv) begin
            f = find(fvpn);
            if (f >= 0) t = f;
            else begin t = m_ptr; m_ptr = (m_ptr + 1) % NE; end
            m_v[t] = 1'b1; m_r[t] = 1'b0; m_d[t] = 1'b0;
            m_vpn[t] = fvpn; m_ppn[t] = fppn; m_rt[t] = fr;
        end
        q_v = lv; q_va = va; q_k = k;
        @(posedge clk);
        @(negedge clk);
        e_hit = 0; e_miss = 0; e_pf = 0; e_wf = 0; e_ref = 0; e_dirty = 0; e_pa = '0;
        if (q_v) begin
            m = find(int'(q_va >> 12));
            if (m < 0) e_miss = 1;
            else begin
                e_ref = m_r[m]; e_dirty = m_d[m];
                if (permitted(q_k, m_rt[m])) begin
                    e_hit = 1;
                    e_pa = {m_ppn[m][19:0], q_va[11:0]};
                end else begin
                    e_pf = 1;
                    e_wf = (q_k == 1);
                end
            end
        end
        cmp(32'(rsp_valid), 32'(q_v), "R2 rsp_valid");
        cmp(32'(rsp_hit), 32'(e_hit), "R5 rsp_hit");
        cmp(32'(rsp_miss), 32'(e_miss), "R4 rsp_miss");
        cmp(rsp_paddr, e_pa, "R3 rsp_paddr");
        cmp(32'(rsp_prot_fault), 32'(e_pf), "R6 rsp_prot_fault");
        cmp(32'(rsp_wr_fault), 32'(e_wf), "R7 rsp_wr_fault");
        cmp(32'(rsp_ref), 32'(e_ref), "R8 rsp_ref");
        cmp(32'(rsp_dirty), 32'(e_dirty), "R9 rsp_dirty");
    endtask

    task automatic idle();
        tick(0, 32'h0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic look(input int vpn, input int off, input int k);
        tick(1, {vpn[19:0], off[11:0]}, k, 0, 0, 0, 0, 0);
    endtask

    task automatic fill(input int vpn, input int ppn, input int r);
        tick(0, 32'h0, 0, 1, vpn, ppn, r, 0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) begin
            m_v[i] = 0; m_r[i] = 0; m_d[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_rt[i] = 0;
        end
        m_ptr = 0; q_v = 0; q_va = '0; q_k = 0;
        rst_n = 1'b0; lk_valid = 0; lk_vaddr = '0; lk_kind = '0;
        fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_rights = '0; flush = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cmp(32'(rsp_valid), 32'd0, "R1 rsp_valid after reset");
        look(20'h00100, 12'h000, 0);
        cmp(32'(rsp_miss), 32'd1, "R1 empty buffer misses");

        // entries 0..5, rights RO,RW,XO,NONE,RW,RO
        fill(20'h00100, 20'h80000, 0);
        fill(20'h00101, 20'h80011, 1);
        fill(20'h00102, 20'h80022, 2);
        fill(20'h00103, 20'h80033, 3);
        fill(20'h00104, 20'h80044, 1);
        fill(20'h00105, 20'h80055, 0);

        look(20'h00100, 12'h345, 0);
        cmp(rsp_paddr, 32'h80000345, "R3 load hit address");
        idle();
        cmp(32'(rsp_valid), 32'd0, "R2 no request no response");
        look(20'h00100, 12'h010, 1);
        cmp(32'(rsp_prot_fault), 32'd1, "R6 store to read-only");
        cmp(32'(rsp_wr_fault), 32'd1, "R7 store fault flag");
        cmp(32'(rsp_hit), 32'd0, "R6 no translation on fault");
        look(20'h00102, 12'hABC, 2);
        cmp(rsp_paddr, 32'h80022ABC, "R5 fetch from execute-only");
        look(20'h00102, 12'h000, 0);
        cmp(32'(rsp_prot_fault), 32'd1, "R5 load from execute-only");
        cmp(32'(rsp_wr_fault), 32'd0, "R7 load fault no store flag");
        look(20'h00103, 12'h000, 0);
        cmp(32'(rsp_prot_fault), 32'd1, "R5 no-access rights");
        look(20'h00104, 12'h000, 3);
        cmp(32'(rsp_prot_fault), 32'd1, "R5 reserved kind denied");
        look(20'h00999, 12'h000, 0);
        cmp(32'(rsp_miss), 32'd1, "R4 unknown page misses");

        look(20'h00101, 12'h004, 1);
        cmp(32'(rsp_dirty), 32'd0, "R9 first store sees clean");
        look(20'h00101, 12'h008, 1);
        cmp(32'(rsp_dirty), 32'd1, "R9 second store sees dirty");
        look(20'h00104, 12'h000, 0);
        look(20'h00104, 12'h000, 0);
        cmp(32'(rsp_ref), 32'd1, "R8 reference set by load");
        cmp(32'(rsp_dirty), 32'd0, "R9 load leaves clean");
        look(20'h00105, 12'h000, 1);
        look(20'h00105, 12'h000, 0);
        cmp(32'(rsp_ref), 32'd0, "R8 fault does not reference");

        // R11 refill in place, then R10 wrap of pointer
        fill(20'h00101, 20'h8F0F0, 0);
        look(20'h00101, 12'h123, 0);
        cmp(rsp_paddr, 32'h8F0F0123, "R11 in-place refill");
        cmp(32'(rsp_dirty), 32'd0, "R9 fill clears dirty");
        for (int i = 0; i < 11; i++) fill(20'h00300 + i, 20'h90000 + i, 1);
        look(20'h00100, 12'h000, 0);
        cmp(32'(rsp_miss), 32'd1, "R10 slot 0 evicted after wrap");
        look(20'h00101, 12'h000, 0);
        cmp(32'(rsp_hit), 32'd1, "R10 R11 slot 1 kept");

        // R12 flush with fill in the same cycle, lookup at same edge
        tick(1, 32'h00101000, 0, 1, 20'h00777, 20'h12345, 1, 1);
        cmp(32'(rsp_miss), 32'd1, "R12 lookup at flush edge misses");
        look(20'h00777, 12'h000, 0);
        cmp(32'(rsp_miss), 32'd1, "R12 flush overrides fill");

        // mixed traffic against the model
        for (int c = 0; c < 3000; c++) begin
            int vp;
            vp = 20'h00200 + int'($urandom % 24);
            tick(($urandom % 4) != 0, {vp[19:0], 12'($urandom)}, int'($urandom % 4),
                 ($urandom % 3) == 0, 20'h00200 + int'($urandom % 24),
                 int'($urandom & 32'hFFFFF), int'($urandom % 4), ($urandom % 97) == 0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule